// File: doc/BRIEF.md
# Dual-Port GPIO Controller with Flash and Sensor Strobes

This block is a word-addressed register file that serves two general-purpose I/O ports, called A and D. Each port has three registers: an output value, an output-enable mask and a read-only input view. A host reaches them through a simple read/write strobe bus. The host supplies a byte address, and the block drops its two low bits to form the word index. The window holds 23 words, so any index from 0 to 22 is inside it. Every word that is not one of the six port registers is plain storage.

Some output bits control attached parts directly. Bits 6, 5 and 4 of the port A output register drive the address-latch, command-latch and chip-enable lines of an external flash. Bit 1 of the port D output register drives a bit-banged serial clock, and bit 4 drives the serial data line. A write that changes the clock bit produces a one-cycle toggle pulse.

Each input view returns the port's output value masked by its output-enable register. Port A bit 7 is also ORed with the flash ready line. Port D bit 4 is also ORed with the sensor's serial output.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After reset every output pin is low, and every storage word, including both output and enable registers, reads as zero.
- R2: A write to an in-window index other than 0x01 or 0x11 takes effect on the clock edge that samples the write strobe. A read returns the stored word combinationally in the same cycle as the read strobe.
- R3: A read of index 0x01 returns (word 0x00 AND word 0x02), with bit 7 ORed with the flash ready input.
- R4: A read of index 0x11 returns (word 0x10 AND word 0x12), with bit 4 ORed with the sensor serial input.
- R5: The flash address-latch, command-latch and chip-enable outputs equal bits 6, 5 and 4 of word 0x00.
- R6: The sensor clock output equals bit 1 of word 0x10, and the sensor data output equals bit 4 of that word.
- R7: In the cycle after a write to index 0x10 that changes bit 1, the toggle pulse output is high for exactly one cycle. A write that leaves bit 1 unchanged produces no pulse.
- R8: The word index is the byte address shifted right by two, so the two low address bits are ignored.
- R9: Reads at an index of 23 or above return zero, and writes there have no effect.
- R10: Writes to index 0x01 or 0x11 have no effect; those reads are always computed as in R3 and R4.
- R11: While the read strobe is low, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| flash_ready_i | input | 1 | Flash ready line |
| sensor_so_i | input | 1 | Sensor serial output |
| flash_ale_o | output | 1 | Flash address-latch enable |
| flash_cle_o | output | 1 | Flash command-latch enable |
| flash_ce_o | output | 1 | Flash chip enable |
| sensor_clk_o | output | 1 | Sensor serial clock |
| sensor_si_o | output | 1 | Sensor serial data in |
| sensor_edge_o | output | 1 | One-cycle clock-toggle pulse |

## Verification
A corrupted output or enable word shows up in the same cycle at the masked read of the matching input index. A corrupted port A word also appears at once on the three flash strobe pins, and a corrupted port D word on the two sensor pins. A wrong previous clock level in the toggle detector shows up one cycle after the next port D write: the pulse is either missing or spurious. A decode fault makes a plain word read back stale or aliased at the next read of that index, or lets a write leak into the input views.

// File: rtl/gpio_pair_pkg.sv
package gpio_pair_pkg;
   // word indices whose behaviour is fixed by the attached devices
   localparam int unsigned IX_A_OUT = 'h00;
   localparam int unsigned IX_A_IN  = 'h01;
   localparam int unsigned IX_A_EN  = 'h02;
   localparam int unsigned IX_D_OUT = 'h10;
   localparam int unsigned IX_D_IN  = 'h11;
   localparam int unsigned IX_D_EN  = 'h12;

   // bit positions decoded by neighbours
   localparam int unsigned B_RDY = 7;
   localparam int unsigned B_ALE = 6;
   localparam int unsigned B_CLE = 5;
   localparam int unsigned B_CE  = 4;
   localparam int unsigned B_SCK = 1;
   localparam int unsigned B_SDA = 4;
   localparam int unsigned B_SSO = 4;

   function automatic bit is_view_index(int unsigned k);
      return (k == IX_A_IN) || (k == IX_D_IN);
   endfunction
endpackage

// File: rtl/gpio_word_store.sv
module gpio_word_store import gpio_pair_pkg::*; #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned WORDS  = 23,
   parameter int unsigned IDX_W  = 6
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [DATA_W-1:0]              wr_data,
   output logic [WORDS-1:0][DATA_W-1:0]   words
);
   for (genvar g = 0; g < WORDS; g++) begin : g_word
      if (is_view_index(g)) begin : g_view
         // input views hold no state of their own
         assign words[g] = '0;
      end else begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && (wr_idx == IDX_W'(g)))
               q <= wr_data;
         end
         assign words[g] = q;
      end
   end
endmodule

// File: rtl/gpio_read_path.sv
module gpio_read_path import gpio_pair_pkg::*; #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned WORDS      = 23,
   parameter int unsigned IDX_W      = 6,
   parameter bit          RDATA_GATE = 1'b1
) (
   input  logic [WORDS-1:0][DATA_W-1:0] words,
   input  logic                         rd_en,
   input  logic [IDX_W-1:0]             rd_idx,
   input  logic                         flash_ready,
   input  logic                         sensor_so,
   output logic [DATA_W-1:0]            rdata
);
   logic [DATA_W-1:0] sel;

   always_comb begin
      sel = '0;
      for (int k = 0; k < WORDS; k++) begin
         if (rd_idx == IDX_W'(k)) sel = words[k];
      end
      if (rd_idx == IDX_W'(IX_A_IN)) begin
         sel = words[IX_A_OUT] & words[IX_A_EN];
         sel[B_RDY] = sel[B_RDY] | flash_ready;
      end
      if (rd_idx == IDX_W'(IX_D_IN)) begin
         sel = words[IX_D_OUT] & words[IX_D_EN];
         sel[B_SSO] = sel[B_SSO] | sensor_so;
      end
   end

   if (RDATA_GATE) begin : g_gated
      assign rdata = rd_en ? sel : '0;
   end else begin : g_open
      logic unused_rd;
      assign unused_rd = rd_en;
      assign rdata = sel;
   end
endmodule

// File: rtl/gpio_toggle_detect.sv
module gpio_toggle_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic new_lvl,
   input  logic cur_lvl,
   output logic pulse
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse <= 1'b0;
      else        pulse <= hit && (new_lvl != cur_lvl);
   end
endmodule

// File: rtl/gpio_pair_ctrl.sv
module gpio_pair_ctrl import gpio_pair_pkg::*; #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned WORDS      = 23,
   parameter bit          RDATA_GATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              flash_ready_i,
   input  logic              sensor_so_i,
   output logic              flash_ale_o,
   output logic              flash_cle_o,
   output logic              flash_ce_o,
   output logic              sensor_clk_o,
   output logic              sensor_si_o,
   output logic              sensor_edge_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   if (DATA_W < 8) begin : g_bad_width
      $error("DATA_W must cover bit 7");
   end
   if (WORDS <= IX_D_EN) begin : g_bad_words
      $error("WORDS must include index 0x12");
   end
   if ((4 * WORDS) > (2 ** ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for WORDS");
   end

   logic [IDX_W-1:0]             idx;
   logic                         in_win;
   logic [WORDS-1:0][DATA_W-1:0] words;
   logic [DATA_W-1:0]            rd_val;
   logic [1:0]                   unused_lsb;

   assign idx        = bus_addr[ADDR_W-1:2];
   assign unused_lsb = bus_addr[1:0];
   assign in_win     = int'(idx) < WORDS;

   gpio_word_store #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bus_wr && in_win),
      .wr_idx  (idx),
      .wr_data (bus_wdata),
      .words   (words)
   );

   gpio_read_path #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W),
                    .RDATA_GATE(RDATA_GATE)) u_read (
      .words       (words),
      .rd_en       (bus_rd),
      .rd_idx      (idx),
      .flash_ready (flash_ready_i),
      .sensor_so   (sensor_so_i),
      .rdata       (rd_val)
   );
   assign bus_rdata = in_win ? rd_val : '0;

   gpio_toggle_detect u_tog (
      .clk     (clk),
      .rst_n   (rst_n),
      .hit     (bus_wr && (idx == IDX_W'(IX_D_OUT))),
      .new_lvl (bus_wdata[B_SCK]),
      .cur_lvl (words[IX_D_OUT][B_SCK]),
      .pulse   (sensor_edge_o)
   );

   assign flash_ale_o  = words[IX_A_OUT][B_ALE];
   assign flash_cle_o  = words[IX_A_OUT][B_CLE];
   assign flash_ce_o   = words[IX_A_OUT][B_CE];
   assign sensor_clk_o = words[IX_D_OUT][B_SCK];
   assign sensor_si_o  = words[IX_D_OUT][B_SDA];
endmodule

// File: rtl/gpio_pair_ctrl_chk.sv
module gpio_pair_ctrl_chk import gpio_pair_pkg::*; #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned WORDS      = 23,
   parameter bit          RDATA_GATE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              flash_ready_i,
   input logic              sensor_so_i,
   input logic              flash_ale_o,
   input logic              flash_cle_o,
   input logic              flash_ce_o,
   input logic              sensor_clk_o,
   input logic              sensor_si_o,
   input logic              sensor_edge_o
);
   localparam int unsigned IDX_W = ADDR_W - 2;
   logic [IDX_W-1:0] ix;
   logic wr_a, wr_d, rd_ain, rd_din, toggles;
   assign ix      = bus_addr[ADDR_W-1:2];
   assign wr_a    = bus_wr && (ix == IDX_W'(IX_A_OUT));
   assign wr_d    = bus_wr && (ix == IDX_W'(IX_D_OUT));
   assign rd_ain  = bus_rd && (ix == IDX_W'(IX_A_IN));
   assign rd_din  = bus_rd && (ix == IDX_W'(IX_D_IN));
   assign toggles = wr_d && (bus_wdata[B_SCK] != sensor_clk_o);

   a_r5_flash_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a |=> (flash_ale_o == $past(bus_wdata[B_ALE])) &&
               (flash_cle_o == $past(bus_wdata[B_CLE])) &&
               (flash_ce_o  == $past(bus_wdata[B_CE])));

   a_r6_clock_source: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sensor_clk_o) |-> $past(wr_d));

   a_r7_pulse_made: assert property (@(posedge clk) disable iff (!rst_n)
      toggles |=> sensor_edge_o);

   a_r7_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
      sensor_edge_o |-> $past(toggles));

   a_r3_ready_merge: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ain && flash_ready_i) |-> bus_rdata[B_RDY]);

   a_r4_serial_merge: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_din && sensor_so_i) |-> bus_rdata[B_SSO]);

   a_r9_outside_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && (int'(ix) >= WORDS)) |-> (bus_rdata == '0));

   if (RDATA_GATE) begin : g_quiet
      a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
         !bus_rd |-> (bus_rdata == '0));
   end
endmodule

bind gpio_pair_ctrl gpio_pair_ctrl_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS), .RDATA_GATE(RDATA_GATE)
) u_chk (.*);

// File: tb/gpio_pair_ctrl_test.sv
module gpio_pair_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        flash_ready_i = 1'b0, sensor_so_i = 1'b0;
   logic        flash_ale_o, flash_cle_o, flash_ce_o;
   logic        sensor_clk_o, sensor_si_o, sensor_edge_o;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   gpio_pair_ctrl uut (.*);

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic        rdy;
      logic        so;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h08, 32'h000000F0, 1'b0, 1'b0, 32'h0,        4'd2},
      '{1'b1, 8'h00, 32'h12345678, 1'b0, 1'b0, 32'h0,        4'd2},
      '{1'b0, 8'h04, 32'h0,        1'b0, 1'b0, 32'h00000070, 4'd3},  // R3
      '{1'b0, 8'h04, 32'h0,        1'b1, 1'b0, 32'h000000F0, 4'd3},  // R3
      '{1'b1, 8'h48, 32'hFFFF00FF, 1'b0, 1'b0, 32'h0,        4'd2},
      '{1'b1, 8'h40, 32'hABCD1234, 1'b0, 1'b0, 32'h0,        4'd2},
      '{1'b0, 8'h44, 32'h0,        1'b0, 1'b0, 32'hABCD0034, 4'd4},  // R4
      '{1'b0, 8'h44, 32'h0,        1'b0, 1'b1, 32'hABCD0034, 4'd4},  // R4
      '{1'b1, 8'h48, 32'h00000000, 1'b0, 1'b0, 32'h0,        4'd2},
      '{1'b0, 8'h44, 32'h0,        1'b0, 1'b1, 32'h00000010, 4'd4},  // R4
      '{1'b0, 8'h44, 32'h0,        1'b0, 1'b0, 32'h00000000, 4'd4},  // R4
      '{1'b1, 8'h14, 32'hCAFEF00D, 1'b0, 1'b0, 32'h0,        4'd2},
      '{1'b0, 8'h14, 32'h0,        1'b0, 1'b0, 32'hCAFEF00D, 4'd2},  // R2
      '{1'b0, 8'h17, 32'h0,        1'b0, 1'b0, 32'hCAFEF00D, 4'd8},  // R8
      '{1'b1, 8'h58, 32'h5A5A5A5A, 1'b0, 1'b0, 32'h0,        4'd2},
      '{1'b0, 8'h58, 32'h0,        1'b0, 1'b0, 32'h5A5A5A5A, 4'd2},  // R2
      '{1'b1, 8'h5C, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0,        4'd9},
      '{1'b0, 8'h5C, 32'h0,        1'b0, 1'b0, 32'h00000000, 4'd9},  // R9
      '{1'b0, 8'h00, 32'h0,        1'b0, 1'b0, 32'h12345678, 4'd2},  // R2
      '{1'b1, 8'h04, 32'hFFFFFFFF, 1'b0, 1'b0, 32'h0,        4'd10},
      '{1'b0, 8'h04, 32'h0,        1'b0, 1'b0, 32'h00000070, 4'd10}  // R10
   };

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_word(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd_word(input logic [7:0] a, input logic rdy, input logic so, output logic [31:0] v);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a; flash_ready_i = rdy; sensor_so_i = so;
      #1 v = bus_rdata;
      #1 bus_rd = 1'b0; flash_ready_i = 1'b0; sensor_so_i = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      // R1: reset state
      check({flash_ale_o, flash_cle_o, flash_ce_o, sensor_clk_o, sensor_si_o, sensor_edge_o} == 6'b0,
            "R1 pins", {26'b0, flash_ale_o, flash_cle_o, flash_ce_o, sensor_clk_o, sensor_si_o, sensor_edge_o}, 32'h0);
      rst_n = 1'b1;
      rd_word(8'h00, 1'b0, 1'b0, v); check(v == 32'h0, "R1 word0", v, 32'h0);
      rd_word(8'h04, 1'b0, 1'b0, v); check(v == 32'h0, "R1 view A", v, 32'h0);
      rd_word(8'h14, 1'b0, 1'b0, v); check(v == 32'h0, "R1 word5", v, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].wr) wr_word(VECS[i].addr, VECS[i].data);
         else begin
            rd_word(VECS[i].addr, VECS[i].rdy, VECS[i].so, v);
            check(v == VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i), v, VECS[i].exp);
         end
      end

      // R5: flash strobes from port A output word (currently 0x12345678)
      check({flash_ale_o, flash_cle_o, flash_ce_o} == 3'b111, "R5 strobes 0x78",
            {29'b0, flash_ale_o, flash_cle_o, flash_ce_o}, 32'h7);
      wr_word(8'h00, 32'h00000040);
      check({flash_ale_o, flash_cle_o, flash_ce_o} == 3'b100, "R5 strobes 0x40",
            {29'b0, flash_ale_o, flash_cle_o, flash_ce_o}, 32'h4);
      wr_word(8'h00, 32'h00000030);
      check({flash_ale_o, flash_cle_o, flash_ce_o} == 3'b011, "R5 strobes 0x30",
            {29'b0, flash_ale_o, flash_cle_o, flash_ce_o}, 32'h3);

      // R6/R7: port D output currently 0xABCD1234 (clk 0, data 1)
      check({sensor_clk_o, sensor_si_o} == 2'b01, "R6 initial pins", {30'b0, sensor_clk_o, sensor_si_o}, 32'h1);
      wr_word(8'h40, 32'h00000012);
      check(sensor_edge_o == 1'b1, "R7 rise pulse", {31'b0, sensor_edge_o}, 32'h1);
      check({sensor_clk_o, sensor_si_o} == 2'b11, "R6 after rise", {30'b0, sensor_clk_o, sensor_si_o}, 32'h3);
      @(posedge clk); #1;
      check(sensor_edge_o == 1'b0, "R7 pulse one cycle", {31'b0, sensor_edge_o}, 32'h0);
      wr_word(8'h40, 32'h00000013);
      check(sensor_edge_o == 1'b0, "R7 no pulse same level", {31'b0, sensor_edge_o}, 32'h0);
      wr_word(8'h40, 32'h00000000);
      check(sensor_edge_o == 1'b1, "R7 fall pulse", {31'b0, sensor_edge_o}, 32'h1);
      check({sensor_clk_o, sensor_si_o} == 2'b00, "R6 after fall", {30'b0, sensor_clk_o, sensor_si_o}, 32'h0);

      // R11: no read strobe, read data quiet
      @(negedge clk); bus_addr = 8'h14; #1;
      check(bus_rdata == 32'h0, "R11 idle read", bus_rdata, 32'h0);

      // R1: reset mid-run clears storage
      @(negedge clk); rst_n = 1'b0; #1;
      check(flash_cle_o == 1'b0, "R1 reset pins", {31'b0, flash_cle_o}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      rd_word(8'h14, 1'b0, 1'b0, v); check(v == 32'h0, "R1 word5 after reset", v, 32'h0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog all requirements actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule